// File: doc/BRIEF.md
# Status-Flag ALU for a 16-bit Microcontroller

This block is the arithmetic and logic unit of a small 16-bit processor core. On every clock it takes a destination operand, a source operand, an opcode, a size select (byte or word) and the current status word. It returns the result, a write-enable for the destination and the new status word. The outputs are registered, so they show the operation that was presented at the previous rising edge.

The block covers eleven two-operand operations and five one-operand operations. The one-operand operations act on the destination operand. Each operation has its own rule for the flags. Logical AND and bit-test report "result non-zero" in carry. XOR raises overflow only when both operands are negative. Bit-set, bit-clear, move and byte swap leave every flag alone. The status word has carry at bit 0, zero at bit 1, negative at bit 2 and overflow at bit 8. Every other status bit passes through unchanged.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `res_o`, `wr_o` and `sr_o` are all zero.
- R2: The outputs register the operation presented at the previous rising edge. The opcode encoding is 0 move, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-carry, 5 compare, 6 AND, 7 bit-test, 8 bit-clear, 9 bit-set, 10 XOR, 11 rotate-right-through-carry, 12 arithmetic right shift, 13 logical right shift, 14 byte swap, 15 sign-extend.
- R3: Add computes dst+src, and add-with-carry computes dst+src+C. Carry is the carry out of the operand width. Overflow is set when the signed result does not fit that width.
- R4: Subtract computes dst + ~src + 1, and subtract-with-carry computes dst + ~src + C. Carry therefore means "no borrow". Overflow follows the signed rule of R3.
- R5: Compare and bit-test update the flags exactly as subtract and AND do, but hold `wr_o` low.
- R6: AND and bit-test set C when the result is non-zero and clear V.
- R7: XOR sets V only when both operands have their sign bit set, and sets C when the result is non-zero.
- R8: Move, bit-clear (dst AND NOT src) and bit-set (dst OR src) write their result and leave `sr_o` equal to `sr_i`.
- R9: Rotate-right-through-carry shifts the old C into the operand MSB. Arithmetic right shift copies the sign bit into the MSB. Logical right shift puts 0 into the MSB. All three move the old LSB into C and clear V.
- R10: Byte swap and sign-extend always work on 16 bits and ignore the size select. Byte swap exchanges the bytes and changes no flag. Sign-extend copies bit 7 into bits 15:8, sets C when the result is non-zero and clears V.
- R11: N is the result's sign bit at the operand width, and Z is set when the result at that width is zero. In byte mode bits 15:8 of `res_o` are zero.
- R12: Status bits other than 0, 1, 2 and 8 always pass from `sr_i` to `sr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte operands, 0 selects word operands |
| dst_i | input | 16 | Destination operand, and the operand of one-operand operations |
| src_i | input | 16 | Source operand |
| sr_i | input | 16 | Current status word |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Destination write-enable |
| sr_o | output | 16 | Updated status word |

## Verification
The bench goes after the width boundaries: 0x7FFF+1 and 0x80+0x80 in byte mode, and 0-1 with and without an incoming carry.
- A design that took carry or sign from the wrong bit would report word flags for byte work.
- A design with an inverted borrow convention would flip C on every subtract.
- A design that leaked upper bits in byte mode would show them in `res_o`.

The bench also covers the flag-preserving operations with every status bit set, where a design with a stray flag update would clear bits. It covers rotates with both carry values, where using the new carry instead of the old one corrupts the MSB, and XOR with one operand negative versus both negative.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DW    = 16,
  parameter int C_POS = 0,
  parameter int Z_POS = 1,
  parameter int N_POS = 2,
  parameter int V_POS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic          byte_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] sr_i,
  output logic [DW-1:0] res_o,
  output logic          wr_o,
  output logic [DW-1:0] sr_o
);
  localparam int BW = DW / 2;
  localparam int IW = $clog2(DW + 1);

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4;
  localparam logic [3:0] OP_CMP  = 4'd5;
  localparam logic [3:0] OP_AND  = 4'd6;
  localparam logic [3:0] OP_BIT  = 4'd7;
  localparam logic [3:0] OP_BIC  = 4'd8;
  localparam logic [3:0] OP_BIS  = 4'd9;
  localparam logic [3:0] OP_XOR  = 4'd10;
  localparam logic [3:0] OP_RRC  = 4'd11;
  localparam logic [3:0] OP_RRA  = 4'd12;
  localparam logic [3:0] OP_RRU  = 4'd13;
  localparam logic [3:0] OP_SWPB = 4'd14;
  localparam logic [3:0] OP_SXT  = 4'd15;

  logic          narrow;
  logic [IW-1:0] msb;
  logic [DW-1:0] mask, a, b, badd, res, sr_n;
  logic [DW:0]   sum;
  logic          c_old, cin, ar_c, ar_v, wr, upd, c_n, v_n, fill;

  assign narrow = byte_i && (op_i != OP_SWPB) && (op_i != OP_SXT);
  assign msb    = narrow ? IW'(BW - 1) : IW'(DW - 1);
  assign mask   = narrow ? {{(DW-BW){1'b0}}, {BW{1'b1}}} : {DW{1'b1}};
  assign a      = dst_i & mask;
  assign b      = src_i & mask;
  assign c_old  = sr_i[C_POS];

  always_comb begin
    badd = b;
    cin  = 1'b0;
    case (op_i)
      OP_ADDC: cin = c_old;
      OP_SUB, OP_CMP: begin badd = ~src_i & mask; cin = 1'b1; end
      OP_SUBC: begin badd = ~src_i & mask; cin = c_old; end
      default: ;
    endcase
  end

  assign sum  = {1'b0, a} + {1'b0, badd} + {{DW{1'b0}}, cin};
  assign ar_c = sum[msb + IW'(1)];
  assign ar_v = (a[msb] == badd[msb]) && (sum[msb] != a[msb]);

  always_comb begin
    res  = a;
    wr   = 1'b1;
    upd  = 1'b0;
    c_n  = 1'b0;
    v_n  = 1'b0;
    fill = 1'b0;
    case (op_i)
      OP_MOV: res = b;
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res = sum[DW-1:0] & mask;
        upd = 1'b1;
        c_n = ar_c;
        v_n = ar_v;
        wr  = (op_i != OP_CMP);
      end
      OP_AND, OP_BIT: begin
        res = a & b;
        upd = 1'b1;
        c_n = |(a & b);
        wr  = (op_i == OP_AND);
      end
      OP_BIC: res = a & ~b;
      OP_BIS: res = a | b;
      OP_XOR: begin
        res = a ^ b;
        upd = 1'b1;
        c_n = |(a ^ b);
        v_n = a[msb] & b[msb];
      end
      OP_RRC, OP_RRA, OP_RRU: begin
        if (op_i == OP_RRC)      fill = c_old;
        else if (op_i == OP_RRA) fill = a[msb];
        res      = a >> 1;
        res[msb] = fill;
        upd      = 1'b1;
        c_n      = a[0];
      end
      OP_SWPB: res = {dst_i[BW-1:0], dst_i[DW-1:BW]};
      OP_SXT: begin
        res = {{(DW-BW){dst_i[BW-1]}}, dst_i[BW-1:0]};
        upd = 1'b1;
        c_n = |res;
      end
      default: ;
    endcase
  end

  always_comb begin
    sr_n = sr_i;
    if (upd) begin
      sr_n[C_POS] = c_n;
      sr_n[Z_POS] = (res == '0);
      sr_n[N_POS] = res[msb];
      sr_n[V_POS] = v_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      wr_o  <= 1'b0;
      sr_o  <= '0;
    end else begin
      res_o <= res;
      wr_o  <= wr;
      sr_o  <= sr_n;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DW    = 16,
  parameter int C_POS = 0,
  parameter int Z_POS = 1,
  parameter int N_POS = 2,
  parameter int V_POS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic          byte_i,
  input logic [DW-1:0] dst_i,
  input logic [DW-1:0] src_i,
  input logic [DW-1:0] sr_i,
  input logic [DW-1:0] res_o,
  input logic          wr_o,
  input logic [DW-1:0] sr_o
);
  localparam int BW = DW / 2;
  logic [DW-1:0] keep;
  always_comb begin
    keep = {DW{1'b1}};
    keep[C_POS] = 1'b0;
    keep[Z_POS] = 1'b0;
    keep[N_POS] = 1'b0;
    keep[V_POS] = 1'b0;
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!rst_n -> (res_o == '0 && !wr_o && sr_o == '0)));

  // compare (5) and bit-test (7)
  a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(op_i) == 4'd5 || $past(op_i) == 4'd7) |-> !wr_o);

  // AND (6): carry means non-zero
  a_r6_and_carry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i) == 4'd6 |-> (sr_o[C_POS] == (res_o != '0)) && !sr_o[V_POS]);

  // move (0), bit-clear (8), bit-set (9), swap (14)
  a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(op_i) == 4'd0 || $past(op_i) == 4'd8 || $past(op_i) == 4'd9 || $past(op_i) == 4'd14)
    |-> sr_o == $past(sr_i));

  a_r10_swap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i) == 4'd14 |-> res_o == {$past(dst_i[BW-1:0]), $past(dst_i[DW-1:BW])});

  a_r11_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(byte_i) && $past(op_i) < 4'd14 |-> res_o[DW-1:BW] == '0);

  a_r12_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sr_o & keep) == ($past(sr_i) & keep));
endmodule

bind flag_alu flag_alu_chk #(.DW(DW), .C_POS(C_POS), .Z_POS(Z_POS), .N_POS(N_POS), .V_POS(V_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i), .dst_i(dst_i), .src_i(src_i),
  .sr_i(sr_i), .res_o(res_o), .wr_o(wr_o), .sr_o(sr_o));

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        byt = 1'b0;
  logic [15:0] dst = '0, src = '0, sr = '0;
  logic [15:0] res_o, sr_o;
  logic        wr_o;

  int n_chk = 0, n_bad = 0;
  bit pend = 0;
  int e_res, e_sr, e_wr, e_op;

  always #2.5 clk = ~clk;

  flag_alu u0 (.clk(clk), .rst_n(rst_n), .op_i(op), .byte_i(byt), .dst_i(dst), .src_i(src),
               .sr_i(sr), .res_o(res_o), .wr_o(wr_o), .sr_o(sr_o));

  function automatic string tag(int o);
    case (o)
      0, 8, 9: return "R8";
      1, 2: return "R3";
      3, 4: return "R4";
      5, 7: return "R5";
      6: return "R6";
      10: return "R7";
      11, 12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int sx(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  task automatic model(int o, int b, int d, int s, int f, output int r, output int w, output int fo);
    int wd, m, sb, u1, u2, c, t, sres, cf, vf, upd;
    wd = (b != 0 && o < 14) ? 8 : 16;
    m = (1 << wd) - 1; sb = 1 << (wd - 1);
    u1 = d & m; u2 = s & m; c = f & 1;
    w = 1; upd = 1; cf = 0; vf = 0; r = u1;
    case (o)
      0: begin r = u2; upd = 0; end
      1, 2: begin
        t = u1 + u2 + ((o == 2) ? c : 0);
        sres = sx(u1, wd) + sx(u2, wd) + ((o == 2) ? c : 0);
        r = t & m; cf = (t > m); vf = (sres < -sb || sres > sb - 1);
      end
      3, 4, 5: begin
        t = u1 + ((~u2) & m) + ((o == 4) ? c : 1);
        sres = sx(u1, wd) - sx(u2, wd) + ((o == 4) ? c - 1 : 0);
        r = t & m; cf = (t > m); vf = (sres < -sb || sres > sb - 1);
        if (o == 5) w = 0;
      end
      6, 7: begin r = u1 & u2; cf = (r != 0); if (o == 7) w = 0; end
      8: begin r = u1 & ~u2 & m; upd = 0; end
      9: begin r = u1 | u2; upd = 0; end
      10: begin r = u1 ^ u2; cf = (r != 0); vf = ((u1 & sb) != 0) && ((u2 & sb) != 0); end
      11: begin r = (u1 >> 1) | (c ? sb : 0); cf = u1 & 1; end
      12: begin r = (u1 >> 1) | (u1 & sb); cf = u1 & 1; end
      13: begin r = u1 >> 1; cf = u1 & 1; end
      14: begin r = ((u1 >> 8) & 255) | ((u1 & 255) << 8); upd = 0; end
      default: begin r = (u1 & 128) ? (u1 | 'hff00) : (u1 & 255); cf = (r != 0); end
    endcase
    fo = f;
    if (upd != 0) begin
      fo = f & ~('h107);
      fo = fo | cf | ((r == 0) ? 2 : 0) | (((r & sb) != 0) ? 4 : 0) | (vf ? 'h100 : 0);
    end
  endtask

  task automatic compare();
    n_chk++;
    if (int'(res_o) != e_res || int'(wr_o) != e_wr || int'(sr_o) != e_sr) begin
      n_bad++;
      $display("FAIL %s op=%0d res=%h wr=%0d sr=%h expected res=%h wr=%0d sr=%h",
               tag(e_op), e_op, res_o, wr_o, sr_o, e_res[15:0], e_wr, e_sr[15:0]);
    end
  endtask

  // R2: each step's outputs are checked on the next falling edge, one rising edge after driving
  task automatic step(int o, int b, int d, int s, int f);
    @(negedge clk);
    if (pend) compare();
    op = 4'(o); byt = 1'(b); dst = 16'(d); src = 16'(s); sr = 16'(f);
    e_op = o;
    model(o, b, d & 'hffff, s & 'hffff, f & 'hffff, e_res, e_wr, e_sr);
    pend = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (res_o != 0 || wr_o != 0 || sr_o != 0) begin
      n_bad++;
      $display("FAIL R1 res=%h wr=%0d sr=%h expected all zero", res_o, wr_o, sr_o);
    end
    rst_n = 1'b1;
    step(1, 0, 'h7fff, 1, 0);          // R3 word overflow
    step(1, 1, 'h1280, 'h0080, 0);     // R3 R11 byte carry + overflow, upper zero
    step(2, 0, 'hffff, 0, 1);          // R3 carry in
    step(3, 0, 0, 1, 0);               // R4 borrow
    step(4, 0, 5, 5, 0);               // R4 subtract-with-carry, C=0
    step(4, 0, 5, 5, 1);               // R4 subtract-with-carry, C=1
    step(5, 0, 'h1234, 'h1234, 'hfef8);// R5 R12 compare equal
    step(7, 1, 'hff0f, 'h00f0, 0);     // R5 R6 bit-test zero
    step(6, 0, 'h8001, 'h8000, 'h0100);// R6 clears V
    step(10, 0, 'h8000, 'h8001, 0);    // R7 both negative
    step(10, 1, 'h0080, 'h0001, 0);    // R7 one negative
    step(8, 0, 'hffff, 'h00ff, 'hffff);// R8 bit-clear keeps flags
    step(9, 1, 'hab01, 'h0010, 'hffff);// R8 R11 bit-set byte
    step(0, 1, 0, 'h12ab, 'h0107);     // R8 move byte
    step(11, 0, 'h0001, 0, 1);         // R9 rotate with C
    step(11, 1, 'h0002, 0, 0);         // R9 rotate without C
    step(12, 0, 'h8002, 0, 0);         // R9 arithmetic shift negative
    step(13, 1, 'h0081, 0, 0);         // R9 logical shift byte
    step(14, 1, 'h12ab, 0, 'h0107);    // R10 swap ignores size
    step(15, 1, 'h0080, 0, 0);         // R10 sign-extend negative
    step(15, 0, 'hff00, 0, 'h0107);    // R10 sign-extend to zero
    for (int i = 0; i < 600; i++)
      step($urandom % 16, $urandom % 2, $urandom % 65536, $urandom % 65536, $urandom % 65536);
    @(negedge clk);
    if (pend) compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule